// File: doc/BRIEF.md
# SD Host Test-Mode Status and Data Stack

This block models the self-test behaviour of an SD host controller's data buffer and its interrupt status logic. A simple single-cycle register bus carries host reads and writes. When test mode is switched on, the data buffer no longer talks to a card. It acts as a stack that only the host can reach: a data-port write pushes a word and a data-port read pops the newest one. Command writes in this mode launch nothing.

A programmed block length (bytes, rounded up to 32-bit words) and block count drive two status events. Write-ready rises when the stack can take one more whole block. Read-ready rises when the stack holds one whole block. Each direction raises at most one event per block and stops once its block count is used up. When DMA is enabled, each event also gives a one-cycle request strobe.

A force control bit lets a test set every status bit whose signal-enable bit is on. While that bit stays at 1, write-one-to-clear writes to the status register are blocked.

Top module: `sdh_tm_top`

Register word addresses:
- 0 = mode: bit 0 test mode, bit 1 DMA enable.
- 1 = test control: bit 0 force.
- 2 = block: bits 10:0 length in bytes, bits 31:16 count.
- 3 = status: write-one-to-clear.
- 4 = signal enable.
- 5 = data port.
- 6 = command.

## Requirements
- R1: After reset every register reads 0. A data-port read returns 0. No strobe output is active.
- R2: A command-register write gives a one-cycle `cmd_start` pulse on the next cycle only while test mode (mode bit 0) is off. While test mode is on, the write starts nothing.
- R3: In test mode a data-port write pushes the word. A data-port read returns the newest word held and removes it, so words come back in reverse order.
- R4: A push when DEPTH words are held is dropped. A pop from an empty stack returns 0 and changes nothing.
- R5: A mode write that turns test mode on from off empties the stack.
- R6: Status bit 4 (write-ready) is set once per block when blocks remain and the free space is at least ceil(length/4) words. The first such event follows a block-register write, and each later one follows the completion of a pushed block.
- R7: Status bit 5 (read-ready) is set once per block when blocks remain and at least ceil(length/4) words are held. The first such event follows a block-register write, and each later one follows the completion of a popped block.
- R8: Each direction keeps its own remaining-block count, loaded by a block-register write. The count drops by one per completed block, and no event is raised in that direction once it reaches 0.
- R9: Writing 1 to the force bit sets every status bit whose signal-enable bit is 1. All other status bits are left alone.
- R10: While the force bit reads 1, status write-one-to-clear writes have no effect. Writing 0 to the force bit clears only the force bit. Clearing works again afterwards.
- R11: With mode bit 1 set, `dma_wr_req` or `dma_rd_req` pulses for one cycle in the same cycle its status bit is set.
- R12: A register read returns its data on `bus_rdata` one cycle later, with `bus_rvalid` high for that one cycle. Unused and reserved bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| cmd_start | output | 1 | Command launch pulse |
| dma_wr_req | output | 1 | Write-direction DMA request strobe |
| dma_rd_req | output | 1 | Read-direction DMA request strobe |

## Verification
The assertions assume that at most one bus operation occurs per cycle. Under that assumption a push, a pop, a mode write and a block-register load never coincide, and stack-level and block-count changes can be attributed to a single cause. The bench drives the bus only through one task per operation, and each task releases the request before the next one starts. The stimulus keeps the block length small enough that the stack depth always holds a block, so the room and level comparisons both take effect.

// File: rtl/sdh_tm_pkg.sv
package sdh_tm_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int LEN_W    = 11;
  localparam int CNT_W    = 16;
  localparam int BIT_WRDY = 4;
  localparam int BIT_RRDY = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 3'd0,
    A_TCTL = 3'd1,
    A_BLK  = 3'd2,
    A_STAT = 3'd3,
    A_ISE  = 3'd4,
    A_DATA = 3'd5,
    A_CMD  = 3'd6
  } reg_addr_e;

  // bytes to 32-bit words, rounded up
  function automatic logic [LEN_W-1:0] len_to_words(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] t;
    t = {1'b0, len} + (LEN_W+1)'(3);
    return {1'b0, t[LEN_W:2]};
  endfunction
endpackage

// File: rtl/sdh_tm_lifo.sv
module sdh_tm_lifo #(
  parameter int DEPTH = 128,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [PW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp;
  logic [AW-1:0] wr_idx, rd_idx;

  assign full    = (sp == PW'(DEPTH));
  assign empty   = (sp == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign level   = sp;
  assign wr_idx  = AW'(sp);
  assign rd_idx  = AW'(sp - PW'(1));
  assign rdata   = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= '0;
    else if (flush)   sp <= '0;
    else if (push_ok) sp <= sp + PW'(1);
    else if (pop_ok)  sp <= sp - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= wdata;
  end

  // R4
  lifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(level));
  // R4
  lifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));
endmodule

// File: rtl/sdh_tm_blkseq.sv
module sdh_tm_blkseq
  import sdh_tm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [LEN_W-1:0] blk_words,
  input  logic             step,
  input  logic             room_ok,
  input  logic             active,
  output logic             evt,
  output logic [CNT_W-1:0] left
);
  logic [LEN_W-1:0] wcnt;
  logic             arm;
  logic             step_v;
  logic             blk_done;

  assign step_v   = step && (left != '0) && (blk_words != '0);
  assign blk_done = step_v && (wcnt + LEN_W'(1) == blk_words);
  assign evt      = active && arm && (left != '0) && (blk_words != '0) && room_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
      wcnt <= '0;
      arm  <= 1'b0;
    end else if (load) begin
      left <= cnt_in;
      wcnt <= '0;
      arm  <= 1'b1;
    end else begin
      if (blk_done) begin
        wcnt <= '0;
        left <= left - CNT_W'(1);
      end else if (step_v) begin
        wcnt <= wcnt + LEN_W'(1);
      end
      if (blk_done)  arm <= 1'b1;
      else if (evt)  arm <= 1'b0;
    end
  end

  // R8
  blk_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !load) |=> (left == $past(left) - CNT_W'(1)));
  // R8
  blk_zero_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0 && !load) |=> (left == '0 && !evt));
endmodule

// File: rtl/sdh_tm_stat.sv
module sdh_tm_stat #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         force_pulse,
  input  logic         force_hold,
  input  logic [W-1:0] ise,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_nx;

  always_comb begin
    stat_nx = stat;
    if (clr_we && !force_hold) stat_nx = stat_nx & ~clr_mask;
    stat_nx = stat_nx | set_vec;
    if (force_pulse) stat_nx = stat_nx | ise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_nx;
  end

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hold && clr_we) |=> ((stat & $past(stat)) == $past(stat)));
  // R9
  stat_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_pulse |=> ((stat & $past(ise)) == $past(ise)));
  // R9
  stat_force_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_pulse && !clr_we && set_vec == '0) |=> (stat == ($past(stat) | $past(ise))));
endmodule

// File: rtl/sdh_tm_top.sv
module sdh_tm_top
  import sdh_tm_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              cmd_start,
  output logic              dma_wr_req,
  output logic              dma_rd_req
);
  localparam int PW = $clog2(DEPTH + 1);

  logic             test_on, dma_on, force_q;
  logic [LEN_W-1:0] blk_len;
  logic [CNT_W-1:0] blk_cnt;
  logic [DATA_W-1:0] ise_q, cmd_q, stat, set_vec, rd_mux;

  logic wr_mode, wr_tctl, wr_blk, wr_stat, wr_ise, wr_data, wr_cmd, rd_data;
  logic enter_test, force_pulse;
  logic push_ok, pop_ok, full, empty;
  logic [PW-1:0] level;
  logic [DATA_W-1:0] top_word;
  logic [LEN_W-1:0]  blk_words;
  logic [15:0] lvl16, words16;
  logic room_ok, held_ok, evt_wr, evt_rd;
  logic [CNT_W-1:0] wr_left, rd_left;

  // decoded bus events
  assign wr_mode = bus_valid && bus_write && (bus_addr == A_MODE);
  assign wr_tctl = bus_valid && bus_write && (bus_addr == A_TCTL);
  assign wr_blk  = bus_valid && bus_write && (bus_addr == A_BLK);
  assign wr_stat = bus_valid && bus_write && (bus_addr == A_STAT);
  assign wr_ise  = bus_valid && bus_write && (bus_addr == A_ISE);
  assign wr_data = bus_valid && bus_write && (bus_addr == A_DATA);
  assign wr_cmd  = bus_valid && bus_write && (bus_addr == A_CMD);
  assign rd_data = bus_valid && !bus_write && (bus_addr == A_DATA);

  assign enter_test  = wr_mode && bus_wdata[0] && !test_on;
  assign force_pulse = wr_tctl && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_on <= 1'b0;
      dma_on  <= 1'b0;
      force_q <= 1'b0;
      blk_len <= '0;
      blk_cnt <= '0;
      ise_q   <= '0;
      cmd_q   <= '0;
    end else begin
      if (wr_mode) begin
        test_on <= bus_wdata[0];
        dma_on  <= bus_wdata[1];
      end
      if (wr_tctl) force_q <= bus_wdata[0];
      if (wr_blk) begin
        blk_len <= bus_wdata[LEN_W-1:0];
        blk_cnt <= bus_wdata[31:16];
      end
      if (wr_ise) ise_q <= bus_wdata;
      if (wr_cmd) cmd_q <= bus_wdata;
    end
  end

  sdh_tm_lifo #(.DEPTH(DEPTH), .W(DATA_W)) u_lifo (
    .clk(clk), .rst_n(rst_n), .flush(enter_test),
    .push(wr_data && test_on), .pop(rd_data && test_on),
    .wdata(bus_wdata), .rdata(top_word), .level(level),
    .full(full), .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  assign blk_words = len_to_words(blk_len);
  assign lvl16     = 16'(level);
  assign words16   = 16'(blk_words);
  assign room_ok   = (lvl16 + words16) <= 16'(DEPTH);
  assign held_ok   = lvl16 >= words16;

  sdh_tm_blkseq u_wseq (
    .clk(clk), .rst_n(rst_n), .load(wr_blk), .cnt_in(bus_wdata[31:16]),
    .blk_words(blk_words), .step(push_ok), .room_ok(room_ok),
    .active(test_on), .evt(evt_wr), .left(wr_left)
  );

  sdh_tm_blkseq u_rseq (
    .clk(clk), .rst_n(rst_n), .load(wr_blk), .cnt_in(bus_wdata[31:16]),
    .blk_words(blk_words), .step(pop_ok), .room_ok(held_ok),
    .active(test_on), .evt(evt_rd), .left(rd_left)
  );

  always_comb begin
    set_vec = '0;
    set_vec[BIT_WRDY] = evt_wr;
    set_vec[BIT_RRDY] = evt_rd;
  end

  sdh_tm_stat #(.W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .force_pulse(force_pulse),
    .force_hold(force_q), .ise(ise_q), .clr_we(wr_stat), .clr_mask(bus_wdata),
    .stat(stat)
  );

  always_comb begin
    unique case (bus_addr)
      A_MODE:  rd_mux = {30'd0, dma_on, test_on};
      A_TCTL:  rd_mux = {31'd0, force_q};
      A_BLK:   rd_mux = {blk_cnt, 5'd0, blk_len};
      A_STAT:  rd_mux = stat;
      A_ISE:   rd_mux = ise_q;
      A_DATA:  rd_mux = test_on ? top_word : '0;
      A_CMD:   rd_mux = cmd_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      cmd_start  <= 1'b0;
      dma_wr_req <= 1'b0;
      dma_rd_req <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
      cmd_start  <= wr_cmd && !test_on;
      dma_wr_req <= evt_wr && dma_on;
      dma_rd_req <= evt_rd && dma_on;
    end
  end

  // R2
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && test_on) |=> !cmd_start);
  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_test |=> (level == '0));
  // R11
  dma_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_req |-> stat[BIT_WRDY]);
  // R11
  dma_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_req |-> stat[BIT_RRDY]);
  // R12
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
endmodule

// File: tb/test_sdh_tm_top.sv
module test_sdh_tm_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, cmd_start, dma_wr_req, dma_rd_req;

  int errors = 0, checks = 0;
  int n_cmd = 0, n_dwr = 0, n_drd = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_tm_top #(.DEPTH(DEPTH)) i_sdh_tm_top (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cmd_start(cmd_start),
    .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each returned read against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_start)  n_cmd++;
      if (dma_wr_req) n_dwr++;
      if (dma_rd_req) n_drd++;
      if (bus_rvalid) begin
        if (exp_q.size() == 0) check("R12 unexpected rvalid", 32'd1, 32'd0);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  localparam logic [2:0] MODE = 3'd0, TCTL = 3'd1, BLK = 3'd2, STAT = 3'd3,
                         ISE = 3'd4, DATA = 3'd5, CMD = 3'd6;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 strobes idle", {29'd0, cmd_start, dma_wr_req, dma_rd_req}, 32'd0);
    rd(MODE, 0, "R1 mode"); rd(TCTL, 0, "R1 tctl"); rd(BLK, 0, "R1 blk");
    rd(STAT, 0, "R1 stat"); rd(ISE, 0, "R1 ise"); rd(CMD, 0, "R1 cmd");
    rd(DATA, 0, "R1 data");
    rd(3'd7, 0, "R12 unmapped");
    // R2 command launch only outside test mode
    wr(CMD, 32'h11);
    wr(MODE, 32'h3);
    rd(MODE, 32'h3, "R12 mode readback");
    wr(CMD, 32'h22);
    @(negedge clk);
    check("R2 cmd pulses", n_cmd, 1);
    // block: 6 bytes -> 2 words, 2 blocks
    wr(BLK, 32'h0002_0006);
    rd(BLK, 32'h0002_0006, "R12 blk readback");
    rd(STAT, 32'h10, "R6 first write-ready");
    check("R11 dma wr first", n_dwr, 1);
    wr(STAT, 32'h10);
    rd(STAT, 32'h0, "R10 w1c clears");
    wr(DATA, 32'hA); wr(DATA, 32'hB);
    rd(STAT, 32'h30, "R6 R7 after first block");
    check("R11 dma wr second", n_dwr, 2);
    check("R11 dma rd first", n_drd, 1);
    wr(STAT, 32'h30);
    wr(DATA, 32'hC); wr(DATA, 32'hD);
    rd(STAT, 32'h0, "R8 write count used up");
    check("R8 no third dma wr", n_dwr, 2);
    // R3 reverse order
    rd(DATA, 32'hD, "R3 pop D"); rd(DATA, 32'hC, "R3 pop C");
    rd(STAT, 32'h20, "R7 read-ready after popped block");
    check("R11 dma rd second", n_drd, 2);
    wr(STAT, 32'h20);
    rd(DATA, 32'hB, "R3 pop B"); rd(DATA, 32'hA, "R3 pop A");
    rd(STAT, 32'h0, "R8 read count used up");
    check("R8 no third dma rd", n_drd, 2);
    rd(DATA, 32'h0, "R4 empty pop");
    // R4 full stack drops extra push
    for (int i = 0; i <= DEPTH; i++) wr(DATA, 32'h100 + i);
    rd(DATA, 32'h100 + DEPTH - 1, "R4 full push dropped");
    rd(DATA, 32'h100 + DEPTH - 2, "R3 next pop");
    // R5 re-entering test mode empties the stack
    wr(MODE, 32'h0); wr(MODE, 32'h3);
    rd(DATA, 32'h0, "R5 flushed");
    // R9 R10 force bit
    wr(ISE, 32'h0000_0101);
    wr(TCTL, 32'h1);
    rd(STAT, 32'h101, "R9 force enabled bits");
    rd(TCTL, 32'h1, "R10 force readback");
    wr(STAT, 32'h101);
    rd(STAT, 32'h101, "R10 clear blocked");
    wr(TCTL, 32'h0);
    rd(STAT, 32'h101, "R10 zero keeps status");
    wr(STAT, 32'h100);
    rd(STAT, 32'h001, "R10 clear after release");
    repeat (3) @(negedge clk);
    check("R12 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule